// File: doc/BRIEF.md
# Masked Host Interrupt Status Aggregator

This block gathers single-cycle event pulses from eight DMA engines (completion and error), from two address-translation units (one facing the AXI side, one facing the PCIe side) and from a local processor. It records them in a 32-bit sticky status register. Next to the status register sits a 32-bit enable mask. Both registers sit behind a simple register port with zero-wait-state reads. Host software clears status bits by writing ones to them.

A host interrupt is pending whenever at least one status bit is set and its mask bit is also set. The block turns that pending condition into message requests. When the MSI-enable input is high, it raises one MSI request on each rising edge of the pending condition. When MSI is disabled, it raises legacy assert and deassert message requests that follow the pending level. Every request is held until it is acknowledged. Building the packets themselves is left to a neighbouring block.

Top module: `host_irq_agg`

## Requirements
- R1: After reset the status register, the mask register, `msiReq` and `legacyReq` are all zero.
- R2: A high pulse on an event input sets its status bit on the next clock edge, and the bit stays set until cleared. The fixed layout is:
  - `dmaDone[i]` sets bit i.
  - `dmaErr[i]` sets bit 8+i.
  - `axiXlatEvt[i]` sets bit 16+i.
  - `pcieXlatEvt[i]` sets bit 20+i.
  - `localIrq[i]` sets bit 24+i.
  
  Several bits may be set at once.
- R3: A write to address 0 clears every status bit whose write-data bit is 1. Status bits whose write-data bit is 0 are unchanged.
- R4: If an event and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: Address 4 holds the mask register, which is read/write. A read of address 0 or 4 returns the current register contents in the same cycle. Other addresses read as zero.
- R6: The pending condition is true when (status AND mask) is nonzero. A set status bit whose mask bit is 0 causes no request.
- R7: With `msiEnable` high, each 0-to-1 change of the pending condition raises `msiReq` one cycle later. `msiReq` stays high until a cycle in which `msiAck` is high, and it is low on the following cycle. New events while the condition is already pending do not raise a further request.
- R8: With `msiEnable` low, the block raises a legacy request whenever the last level it requested differs from the pending condition and no request is outstanding. For an assert message, `legacyReq` is high with `legacyLevel` = 1. For a deassert message, `legacyReq` is high with `legacyLevel` = 0.
  - Each request is held, with a stable level, until a cycle in which `legacyAck` is high.
  - A deassert request is issued after a still-outstanding assert request has been acknowledged, and never in its place.
- R9: No assert-level legacy request is raised while `msiEnable` is high. No MSI request is raised while `msiEnable` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dmaDone | input | 8 | DMA engine completion pulses |
| dmaErr | input | 8 | DMA engine error pulses |
| axiXlatEvt | input | 4 | AXI-side address translation event pulses |
| pcieXlatEvt | input | 4 | PCIe-side address translation event pulses |
| localIrq | input | 8 | Local processor interrupt request pulses |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register byte address (0 = status, 4 = mask) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational |
| msiEnable | input | 1 | Selects MSI (1) or legacy messages (0) |
| msiReq | output | 1 | MSI request, held until acknowledged |
| msiAck | input | 1 | MSI request acknowledge |
| legacyReq | output | 1 | Legacy interrupt message request |
| legacyLevel | output | 1 | Legacy message kind: 1 = assert, 0 = deassert |
| legacyAck | input | 1 | Legacy message request acknowledge |

## Verification
On every cycle, the assertions check four things:
- status bits never drop except under a status write;
- an event is never lost to a same-cycle clear;
- requests of both kinds hold steady until acknowledged;
- every request traces back to a pending condition in the matching mode.

Only the bench scenarios can show the exact field position of each source, and that masked sources stay silent. They also show the single MSI pulse per rising edge rather than one per event, and the assert-then-deassert ordering when the condition falls before the assert message is acknowledged.

// File: rtl/host_irq_pkg.sv
package host_irq_pkg;
  localparam int DMA_N  = 8;
  localparam int XLAT_N = 4;
  localparam int LOC_N  = 8;
  localparam int REG_W  = 2 * DMA_N + 2 * XLAT_N + LOC_N;

  typedef struct packed {
    logic wrStatus;
    logic wrMask;
    logic rdStatus;
    logic rdMask;
  } regStrobe_t;
endpackage

// File: rtl/host_irq_regs.sv
module host_irq_regs
  import host_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strb,
  input  logic [REG_W-1:0] wrData,
  input  logic [REG_W-1:0] evtVec,
  output logic [REG_W-1:0] rdData,
  output logic [REG_W-1:0] statusQ,
  output logic [REG_W-1:0] maskQ,
  output logic             pendAny
);
  logic [REG_W-1:0] clrVec;

  assign clrVec  = strb.wrStatus ? wrData : '0;
  assign pendAny = |(statusQ & maskQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '0;
    end else begin
      statusQ <= (statusQ & ~clrVec) | evtVec;
      if (strb.wrMask) maskQ <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    if (strb.rdStatus) rdData = statusQ;
    else if (strb.rdMask) rdData = maskQ;
  end
endmodule

// File: rtl/host_irq_ctrl.sv
module host_irq_ctrl
  import host_irq_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              pendAny,
  input  logic              msiEnable,
  input  logic              msiAck,
  input  logic              legacyAck,
  output regStrobe_t        strb,
  output logic              msiReq,
  output logic              legacyReq,
  output logic              legacyLevel
);
  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] MASK_ADDR   = ADDR_W'(4);

  logic pendPrev;
  logic lineQ;
  logic pendRise;
  logic legTarget;

  assign strb.rdStatus = (regAddr == STATUS_ADDR);
  assign strb.rdMask   = (regAddr == MASK_ADDR);
  assign strb.wrStatus = regWr && strb.rdStatus;
  assign strb.wrMask   = regWr && strb.rdMask;

  assign pendRise  = pendAny && !pendPrev;
  assign legTarget = pendAny && !msiEnable;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendPrev    <= 1'b0;
      msiReq      <= 1'b0;
      legacyReq   <= 1'b0;
      legacyLevel <= 1'b0;
      lineQ       <= 1'b0;
    end else begin
      pendPrev <= pendAny;
      msiReq   <= (msiReq && !msiAck) || (pendRise && msiEnable);
      if (legacyReq) begin
        if (legacyAck) legacyReq <= 1'b0;
      end else if (legTarget != lineQ) begin
        legacyReq   <= 1'b1;
        legacyLevel <= legTarget;
        lineQ       <= legTarget;
      end
    end
  end
endmodule

// File: rtl/host_irq_agg.sv
module host_irq_agg
  import host_irq_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DMA_N-1:0]  dmaDone,
  input  logic [DMA_N-1:0]  dmaErr,
  input  logic [XLAT_N-1:0] axiXlatEvt,
  input  logic [XLAT_N-1:0] pcieXlatEvt,
  input  logic [LOC_N-1:0]  localIrq,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              msiEnable,
  output logic              msiReq,
  input  logic              msiAck,
  output logic              legacyReq,
  output logic              legacyLevel,
  input  logic              legacyAck
);
  regStrobe_t       strb;
  logic [REG_W-1:0] evtVec;
  logic [REG_W-1:0] statusQ;
  logic [REG_W-1:0] maskQ;
  logic             pendAny;

  assign evtVec = {localIrq, pcieXlatEvt, axiXlatEvt, dmaErr, dmaDone};

  host_irq_regs u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (regWrData),
    .evtVec  (evtVec),
    .rdData  (regRdData),
    .statusQ (statusQ),
    .maskQ   (maskQ),
    .pendAny (pendAny)
  );

  host_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .regWr       (regWr),
    .regAddr     (regAddr),
    .pendAny     (pendAny),
    .msiEnable   (msiEnable),
    .msiAck      (msiAck),
    .legacyAck   (legacyAck),
    .strb        (strb),
    .msiReq      (msiReq),
    .legacyReq   (legacyReq),
    .legacyLevel (legacyLevel)
  );
endmodule

// File: rtl/host_irq_chk.sv
module host_irq_chk
  import host_irq_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWr,
  input logic [ADDR_W-1:0] regAddr,
  input logic              msiEnable,
  input logic              msiReq,
  input logic              msiAck,
  input logic              legacyReq,
  input logic              legacyLevel,
  input logic              legacyAck,
  input logic [REG_W-1:0]  statusQ,
  input logic [REG_W-1:0]  evtVec,
  input logic              pendAny
);
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !(regWr && regAddr == ADDR_W'(0)) |=> (($past(statusQ) & ~statusQ) == '0)); // R3

  AST_EVENT_NOT_LOST: assert property (@(posedge clk) disable iff (!rstN)
    (evtVec != '0) |=> (($past(evtVec) & ~statusQ) == '0)); // R4

  AST_MSI_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (msiReq && !msiAck) |=> msiReq); // R7

  AST_MSI_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(msiReq) |-> ($past(pendAny) && $past(msiEnable))); // R9

  AST_LEGACY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (legacyReq && !legacyAck) |=> (legacyReq && $stable(legacyLevel))); // R8

  AST_LEGACY_ASSERT_MODE: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(legacyReq) && legacyLevel) |-> ($past(pendAny) && !$past(msiEnable))); // R9
endmodule

bind host_irq_agg host_irq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/host_irq_agg_bench.sv
`timescale 1ns/1ps
module host_irq_agg_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  dmaDone = '0;
  logic [7:0]  dmaErr = '0;
  logic [3:0]  axiXlatEvt = '0;
  logic [3:0]  pcieXlatEvt = '0;
  logic [7:0]  localIrq = '0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        msiEnable = 1'b0;
  logic        msiReq;
  logic        msiAck = 1'b0;
  logic        legacyReq;
  logic        legacyLevel;
  logic        legacyAck = 1'b0;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  host_irq_agg u_host_irq_agg (.*);

  // {event word, expected cumulative status}
  localparam logic [63:0] VECS [6] = '{
    {32'h0000_0001, 32'h0000_0001},
    {32'h0000_8000, 32'h0000_8001},
    {32'h0001_0000, 32'h0001_8001},
    {32'h0080_0000, 32'h0081_8001},
    {32'h8000_0000, 32'h8081_8001},
    {32'h0100_0000, 32'h8181_8001}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setEvt(logic [31:0] w);
    dmaDone     = w[7:0];
    dmaErr      = w[15:8];
    axiXlatEvt  = w[19:16];
    pcieXlatEvt = w[23:20];
    localIrq    = w[31:24];
  endtask

  task automatic pulse(logic [31:0] w);
    @(negedge clk); setEvt(w);
    @(negedge clk); setEvt('0);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWr = 1'b0; regWrData = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    regAddr = a; #1; d = regRdData;
  endtask

  task automatic ackLeg();
    @(negedge clk); legacyAck = 1'b1;
    @(negedge clk); legacyAck = 1'b0;
  endtask

  task automatic ackMsi();
    @(negedge clk); msiAck = 1'b1;
    @(negedge clk); msiAck = 1'b0;
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    rd(3'd0, d); chk("R1 status reset", d, 32'h0);
    rd(3'd4, d); chk("R1 mask reset", d, 32'h0);
    chk("R1 msiReq reset", {31'h0, msiReq}, 32'h0);
    chk("R1 legacyReq reset", {31'h0, legacyReq}, 32'h0);

    for (int i = 0; i < 6; i++) begin
      pulse(VECS[i][63:32]);
      @(negedge clk);
      rd(3'd0, d); chk("R2 field map sticky", d, VECS[i][31:0]);
      chk("R6 masked no legacy", {31'h0, legacyReq}, 32'h0);
      chk("R6 masked no msi", {31'h0, msiReq}, 32'h0);
    end
    wr(3'd0, 32'h0000_8000);
    rd(3'd0, d); chk("R3 selective clear", d, 32'h8181_0001);
    wr(3'd0, 32'h0);
    rd(3'd0, d); chk("R3 zero write no effect", d, 32'h8181_0001);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, d); chk("R3 clear all", d, 32'h0);

    pulse(32'h0000_0004);
    @(negedge clk); regWr = 1'b1; regAddr = 3'd0; regWrData = 32'h0000_0004; dmaDone = 8'h04;
    @(negedge clk); regWr = 1'b0; regWrData = '0; dmaDone = '0;
    rd(3'd0, d); chk("R4 set wins over clear", d, 32'h0000_0004);
    wr(3'd0, 32'h0000_0004);

    wr(3'd4, 32'h1234_ABCD);
    rd(3'd4, d); chk("R5 mask readback", d, 32'h1234_ABCD);
    rd(3'd2, d); chk("R5 unmapped reads zero", d, 32'h0);
    wr(3'd4, 32'hFFFF_FFFF);

    pulse(32'h0800_0000);
    @(negedge clk);
    chk("R8 assert req", {30'h0, legacyReq, legacyLevel}, 32'h3);
    chk("R9 no msi in legacy", {31'h0, msiReq}, 32'h0);
    repeat (3) @(negedge clk);
    chk("R8 assert held", {30'h0, legacyReq, legacyLevel}, 32'h3);
    ackLeg();
    chk("R8 dropped after ack", {31'h0, legacyReq}, 32'h0);
    wr(3'd0, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R8 deassert req", {30'h0, legacyReq, legacyLevel}, 32'h2);
    ackLeg();

    pulse(32'h0200_0000);
    @(negedge clk);
    chk("R8 order assert", {30'h0, legacyReq, legacyLevel}, 32'h3);
    wr(3'd0, 32'hFFFF_FFFF);
    chk("R8 order assert still held", {30'h0, legacyReq, legacyLevel}, 32'h3);
    ackLeg();
    chk("R8 order gap after ack", {31'h0, legacyReq}, 32'h0);
    @(negedge clk);
    chk("R8 order deassert follows", {30'h0, legacyReq, legacyLevel}, 32'h2);
    ackLeg();

    wr(3'd4, 32'hFFFF_FFDF);
    pulse(32'h0000_0020);
    repeat (3) @(negedge clk);
    chk("R6 masked source silent", {31'h0, legacyReq}, 32'h0);
    rd(3'd0, d); chk("R6 masked bit still recorded", d, 32'h0000_0020);
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd4, 32'hFFFF_FFFF);

    msiEnable = 1'b1;
    pulse(32'h0000_0400);
    @(negedge clk);
    chk("R7 msi raised", {31'h0, msiReq}, 32'h1);
    chk("R9 no legacy in msi", {31'h0, legacyReq}, 32'h0);
    repeat (3) @(negedge clk);
    chk("R7 msi held", {31'h0, msiReq}, 32'h1);
    ackMsi();
    chk("R7 msi dropped", {31'h0, msiReq}, 32'h0);
    pulse(32'h0002_0000);
    repeat (3) @(negedge clk);
    chk("R7 no repeat while pending", {31'h0, msiReq}, 32'h0);
    wr(3'd0, 32'hFFFF_FFFF);
    pulse(32'h0080_0000);
    @(negedge clk);
    chk("R7 msi on new rise", {31'h0, msiReq}, 32'h1);
    ackMsi();
    chk("R9 legacy quiet in msi", {31'h0, legacyReq}, 32'h0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule